// File: doc/BRIEF.md
# Clocked Serial Byte Shifter

This block is the byte-wide synchronous serial port of a small controller. It holds one data byte. It sends that byte on a serial output pin and, during the same transfer, captures a byte from a serial input pin. Both pins are timed by a shift clock. The shift clock comes either from an internal divider or from an external pin.

A four-state sequencer drives each transfer. The states are idle, armed (waiting for the first clock), shifting, and free-running clock. Three things move the sequencer: a start strobe, writes to the primary mode register, and the clock edges it counts.

Software programs the block through a plain register port. A write takes effect on the next clock edge and is never stalled. The register port has no valid/ready handshake because there is no streaming interface. Completion is shown by a sticky done pin.

Top module: `sio_shift_ctrl`

## Requirements
- R1: After reset the block is idle, the internal clock is parked high, `sck_oe` is 0, `done` is 0, `sdo` is 1, and the data register reads 0.
- R2: While idle, clock edges on the selected source do not shift the data register and do not change `sdo`.
- R3: A start strobe while idle arms the block and clears `done`. In internal mode the divider starts running, with `sck_o` high first.
- R4: In internal mode the shift clock period is 2^(12 - 2a + b) cycles of `clk`. Here a = mode A bits [2:0] (values 6 and 7 act as 5) and b = mode B bit 0. The possible periods run from 4 to 8192 cycles.
- R5: Bits leave least significant first. `sdo` takes data bit 0 on each falling clock edge. Each rising edge shifts the register right and puts `sdi` into bit 7. After a full transfer the data register (address 2) holds the received byte.
- R6: In internal mode (mode A bit 3 = 1) a transfer produces exactly eight clock pulses. The block then sets `done`, returns to idle and parks `sck_o` high.
- R7: In external mode (mode A bit 3 = 0) the block re-arms after eight clocks. The next falling edge starts another transfer without a start strobe, and `done` stays set.
- R8: A write to mode A (address 0) while armed returns the block to idle. Later clock edges are then ignored.
- R9: A start strobe during shifting aborts the transfer, clears the 3-bit edge counter and re-arms the block. The next transfer needs a full eight clocks before `done` is set.
- R10: With internal mode and continuous mode both set (mode A bit 4 = 1), the first clock leads to free-running output. In that state clocks never shift data or set `done`. Only a write to mode A (or reset) stops the clock, which then parks high.
- R11: If a start strobe falls in the same cycle as the eighth rising edge, the start wins. `done` stays clear, the block re-arms, and the clock keeps running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one cycle is the divider's unit of time |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 mode A, 1 mode B, 2 data |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 8 | Read data for `rd_addr` |
| start | input | 1 | One-cycle start command |
| sck_o | output | 1 | Generated shift clock |
| sck_oe | output | 1 | High when the block drives the shift clock (internal mode) |
| sck_i | input | 1 | External shift clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| done | output | 1 | Sticky transfer-complete flag |

## Verification
The start strobe and the completing eighth rising edge can land on the same cycle. The bench provokes this in internal mode with the fastest divider. It counts seven rising edges on `sck_o` and then places the strobe exactly four `clk` cycles later. It judges the result by three things: `done` stays low, the clock keeps running, and precisely eight further pulses arrive before `done` finally rises. Clock-driven shifting is judged by a scoreboard that predicts every `sdo` bit from the byte loaded.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DATA_W   = 8;
  localparam int CNT_W    = $clog2(DATA_W);
  localparam int RATE_W   = 3;
  localparam int RATE_MAX = 5;
  localparam int LOG_TOP  = 12;
  localparam int SYNC_STG = 2;

  localparam int MA_W     = 5;
  localparam int MA_INT   = 3;
  localparam int MA_CONT  = 4;

  typedef enum logic [1:0] {
    ADDR_MODEA = 2'd0,
    ADDR_MODEB = 2'd1,
    ADDR_DATA  = 2'd2
  } sio_addr_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_SHIFT,
    ST_FREE
  } sio_state_e;
endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
  parameter int LOG_TOP  = 12,
  parameter int RATE_W   = 3,
  parameter int RATE_MAX = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [RATE_W-1:0] rate_a,
  input  logic              rate_b,
  output logic              sck_q,
  output logic              fall_evt,
  output logic              rise_evt
);
  localparam int HC_W = LOG_TOP + 1;

  logic [HC_W-1:0] hcnt_q;
  logic [HC_W-1:0] lim;
  logic            toggle;
  int              a_eff;
  int              hlog;

  // half period = 2^(LOG_TOP-1-2a+b) cycles
  always_comb begin
    a_eff = (int'(rate_a) > RATE_MAX) ? RATE_MAX : int'(rate_a);
    hlog  = LOG_TOP - 1 - 2 * a_eff + int'(rate_b);
    lim   = HC_W'((1 << hlog) - 1);
  end

  assign toggle   = active && (hcnt_q == lim);
  assign fall_evt = toggle && sck_q;
  assign rise_evt = toggle && !sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      sck_q  <= 1'b1;
    end else if (!active) begin
      hcnt_q <= '0;
      sck_q  <= 1'b1;
    end else if (toggle) begin
      hcnt_q <= '0;
      sck_q  <= ~sck_q;
    end else begin
      hcnt_q <= hcnt_q + 1'b1;
    end
  end

  assert_sck_parks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> sck_q);
  assert_gap_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !toggle) |=> $stable(sck_q) || !active || $past(toggle));
endmodule

// File: rtl/sio_ext_edge.sv
module sio_ext_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall_evt,
  output logic rise_evt
);
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[STAGES-1:0], pin};
  end

  assign fall_evt = sync_q[STAGES] && !sync_q[STAGES-1];
  assign rise_evt = !sync_q[STAGES] && sync_q[STAGES-1];
endmodule

// File: rtl/sio_seq.sv
module sio_seq import sio_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              modea_wr,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              int_mode,
  input  logic              cont_mode,
  input  logic              fall_evt,
  input  logic              rise_evt,
  input  logic              sdi,
  output sio_state_e        st_q,
  output logic [DATA_W-1:0] sh_q,
  output logic              sdo_q,
  output logic              done_q
);
  sio_state_e        st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_d;
  logic              sdo_d, done_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    sdo_d  = sdo_q;
    done_d = done_q;
    if (data_wr && st_q != ST_SHIFT) sh_d = wr_data;
    if (start) done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d  = ST_ARMED;
          cnt_d = '0;
        end
      end
      ST_ARMED: begin
        if (modea_wr) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else if (start) begin
          cnt_d = '0;
        end else if (fall_evt) begin
          cnt_d = cnt_q + 1'b1;
          sdo_d = sh_q[0];
          st_d  = (int_mode && cont_mode) ? ST_FREE : ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (start) begin
          st_d  = ST_ARMED;
          cnt_d = '0;
        end else if (rise_evt) begin
          sh_d = {sdi, sh_q[DATA_W-1:1]};
          if (cnt_q == '0) begin
            done_d = 1'b1;
            st_d   = int_mode ? ST_IDLE : ST_ARMED;
          end
        end else if (fall_evt) begin
          cnt_d = cnt_q + 1'b1;
          sdo_d = sh_q[0];
        end
      end
      ST_FREE: begin
        if (modea_wr) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      sdo_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      sdo_q  <= sdo_d;
      done_q <= done_d;
    end
  end

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !start) |=> (st_q == ST_IDLE && $stable(sdo_q)));
  assert_start_clears_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done_q);
  assert_done_from_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(st_q) == ST_SHIFT);
  assert_armed_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARMED && modea_wr) |=> st_q == ST_IDLE);
  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SHIFT && start) |=> (st_q == ST_ARMED && cnt_q == '0 && !done_q));
  assert_free_stays_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FREE && !modea_wr) |=> (st_q == ST_FREE && !done_q));
endmodule

// File: rtl/sio_shift_ctrl.sv
module sio_shift_ctrl import sio_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              start,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sck_i,
  input  logic              sdi,
  output logic              sdo,
  output logic              done
);
  logic [MA_W-1:0]   modea_q;
  logic              modeb_q;
  logic              modea_wr, modeb_wr, data_wr;
  logic              int_mode, cont_mode;
  logic              gen_active, gen_fall, gen_rise;
  logic              ext_fall, ext_rise;
  logic              fall_evt, rise_evt;
  sio_state_e        st;
  logic [DATA_W-1:0] sh;

  assign modea_wr = wr_en && (wr_addr == ADDR_MODEA);
  assign modeb_wr = wr_en && (wr_addr == ADDR_MODEB);
  assign data_wr  = wr_en && (wr_addr == ADDR_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modea_q <= '0;
      modeb_q <= 1'b0;
    end else begin
      if (modea_wr) modea_q <= wr_data[MA_W-1:0];
      if (modeb_wr) modeb_q <= wr_data[0];
    end
  end

  assign int_mode   = modea_q[MA_INT];
  assign cont_mode  = modea_q[MA_CONT];
  assign gen_active = int_mode && (st != ST_IDLE);

  sio_clkgen #(.LOG_TOP(LOG_TOP), .RATE_W(RATE_W), .RATE_MAX(RATE_MAX)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (gen_active),
    .rate_a   (modea_q[RATE_W-1:0]),
    .rate_b   (modeb_q),
    .sck_q    (sck_o),
    .fall_evt (gen_fall),
    .rise_evt (gen_rise)
  );

  sio_ext_edge #(.STAGES(SYNC_STG)) u_ext_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (sck_i),
    .fall_evt (ext_fall),
    .rise_evt (ext_rise)
  );

  assign fall_evt = int_mode ? gen_fall : ext_fall;
  assign rise_evt = int_mode ? gen_rise : ext_rise;

  sio_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .modea_wr  (modea_wr),
    .data_wr   (data_wr),
    .wr_data   (wr_data),
    .int_mode  (int_mode),
    .cont_mode (cont_mode),
    .fall_evt  (fall_evt),
    .rise_evt  (rise_evt),
    .sdi       (sdi),
    .st_q      (st),
    .sh_q      (sh),
    .sdo_q     (sdo),
    .done_q    (done)
  );

  assign sck_oe = int_mode;

  always_comb begin
    unique case (rd_addr)
      ADDR_MODEA: rd_data = DATA_W'(modea_q);
      ADDR_MODEB: rd_data = DATA_W'(modeb_q);
      ADDR_DATA:  rd_data = sh;
      default:    rd_data = '0;
    endcase
  end

  assert_ext_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !int_mode |-> !sck_oe);
endmodule

// File: tb/sio_shift_ctrl_bench.sv
module sio_shift_ctrl_bench;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       start = 1'b0;
  logic       sck_o, sck_oe, sdo, done;
  logic       sck_drv = 1'b1;
  logic       sdi = 1'b0;

  int tests_run = 0;
  int tests_failed = 0;
  int rise_cnt = 0;
  bit mon_en = 0;
  bit rx_en = 0;
  logic exp_q[$];
  logic rx_q[$];

  always #(CLK_NS/2) clk = ~clk;

  sio_shift_ctrl u_sio_shift_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .start(start), .sck_o(sck_o),
    .sck_oe(sck_oe), .sck_i(sck_drv), .sdi(sdi), .sdo(sdo), .done(done)
  );

  wire sck_line = sck_oe ? sck_o : sck_drv;

  task automatic chk(input string req, input int act, input int exp);
    tests_run++;
    if (act != exp) begin
      tests_failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_tx(input logic [7:0] b);
    for (int i = 0; i < 8; i++) exp_q.push_back(b[i]);
  endtask

  task automatic push_rx(input logic [7:0] b);
    for (int i = 0; i < 8; i++) rx_q.push_back(b[i]);
  endtask

  // scoreboard monitor: each rising shift clock edge pops the predicted sdo bit
  always @(posedge sck_line) begin
    if (mon_en) begin
      #1;
      if (exp_q.size() == 0) chk("R5 extra clock edge", 1, 0);
      else chk("R5 sdo bit", int'(sdo), int'(exp_q.pop_front()));
    end
  end

  always @(negedge sck_line) begin
    if (rx_en && rx_q.size() > 0) sdi = rx_q.pop_front();
  end

  always @(posedge sck_o) rise_cnt++;

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic go();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (8) @(negedge clk);
      sck_drv = 1'b0;
      repeat (8) @(negedge clk);
      sck_drv = 1'b1;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic period_case(input logic [2:0] a, input logic b, input int expc);
    realtime t1, t2;
    wr(2'd1, {7'd0, b});
    wr(2'd0, {4'b0001, 1'b0, a} & 8'h0F | 8'h08);
    go();
    @(negedge sck_o); t1 = $realtime;
    @(negedge sck_o); t2 = $realtime;
    chk("R4 period", int'((t2 - t1) / CLK_NS), expc);
    wait (done);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 200000);
    chk("watchdog expired", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int base;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 done", int'(done), 0);
    chk("R1 sck_o", int'(sck_o), 1);
    chk("R1 sck_oe", int'(sck_oe), 0);
    chk("R1 sdo", int'(sdo), 1);
    rd(2'd2, d);
    chk("R1 data", int'(d), 0);

    // R2 edges ignored while idle (external mode)
    wr(2'd2, 8'h5A);
    ext_pulses(3);
    rd(2'd2, d);
    chk("R2 data unchanged", int'(d), 8'h5A);
    chk("R2 sdo unchanged", int'(sdo), 1);

    // R5 R7 external transfer, then automatic re-arm
    wr(2'd2, 8'hC3);
    push_tx(8'hC3); push_rx(8'h96);
    mon_en = 1; rx_en = 1;
    go();
    chk("R3 done cleared by start", int'(done), 0);
    ext_pulses(8);
    chk("R7 done after eight", int'(done), 1);
    rd(2'd2, d);
    chk("R5 received byte", int'(d), 8'h96);
    push_tx(8'h96); push_rx(8'h0F);
    ext_pulses(8);
    chk("R7 done still set", int'(done), 1);
    rd(2'd2, d);
    chk("R7 second byte without start", int'(d), 8'h0F);
    chk("R5 scoreboard drained", exp_q.size(), 0);
    mon_en = 0; rx_en = 0; sdi = 1'b0;

    // R8 mode A write while armed returns to idle
    wr(2'd2, 8'h81);
    go();
    wr(2'd0, 8'h00);
    ext_pulses(2);
    rd(2'd2, d);
    chk("R8 data unchanged after disarm", int'(d), 8'h81);

    // R9 abort during shifting
    wr(2'd2, 8'hF0);
    go();
    ext_pulses(3);
    go();
    chk("R9 done clear after abort", int'(done), 0);
    push_tx(8'h1E);
    mon_en = 1;
    ext_pulses(7);
    chk("R9 no done after seven", int'(done), 0);
    ext_pulses(1);
    chk("R9 done after full eight", int'(done), 1);
    rd(2'd2, d);
    chk("R9 received zeros", int'(d), 0);
    mon_en = 0;

    // R3 R5 R6 internal transfer at fastest rate
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h0D);
    chk("R3 sck_oe internal", int'(sck_oe), 1);
    wr(2'd2, 8'hA5);
    push_tx(8'hA5); push_rx(8'h3C);
    mon_en = 1; rx_en = 1;
    rise_cnt = 0;
    go();
    chk("R3 clock high first", int'(sck_o), 1);
    wait (done);
    repeat (40) @(negedge clk);
    chk("R6 exactly eight pulses", rise_cnt, 8);
    chk("R6 clock parked high", int'(sck_o), 1);
    rd(2'd2, d);
    chk("R5 internal received", int'(d), 8'h3C);
    chk("R5 internal scoreboard drained", exp_q.size(), 0);
    mon_en = 0; rx_en = 0; sdi = 1'b0;

    // R4 divider periods
    period_case(3'd3, 1'b1, 128);
    period_case(3'd5, 1'b1, 8);
    period_case(3'd7, 1'b0, 4);
    period_case(3'd0, 1'b0, 4096);

    // R10 free-running clock
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h77);
    wr(2'd0, 8'h1D);
    go();
    repeat (20) @(negedge sck_o);
    chk("R10 no done while free", int'(done), 0);
    rd(2'd2, d);
    chk("R10 data not shifted", int'(d), 8'h77);
    wr(2'd0, 8'h0D);
    repeat (4) @(negedge clk);
    rise_cnt = 0;
    repeat (40) @(negedge clk);
    chk("R10 clock stopped", rise_cnt, 0);
    chk("R10 parked high", int'(sck_o), 1);

    // R11 start on the same cycle as the eighth rising edge
    wr(2'd2, 8'h00);
    go();
    chk("R11 done cleared", int'(done), 0);
    repeat (7) @(posedge sck_o);
    repeat (4) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rise_cnt = 0;
    base = 0;
    @(negedge clk);
    chk("R11 start wins over completion", int'(done), 0);
    wait (done);
    repeat (20) @(negedge clk);
    chk("R11 clock continued, eight more", rise_cnt, 8 + base);

    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule